// File: doc/BRIEF.md
# Byte-Lane Mask Pipeline for a Synchronous DRAM Data Path

This block sits between a 16-bit synchronous DRAM-style data bus and its storage array. It applies two active-high byte-mask inputs in two directions. On the write side, a lane whose mask is high at a clock edge gets no write enable toward the array in that same cycle. On the read side, the same mask works as an output disable, but it takes effect two clock cycles after it is sampled. A disabled lane has its output enable low and its data lines driven to zero.

A beat-position counter advances on every read or write beat, whether or not the beat is masked. A burst-start strobe restarts the count. Data leaves the block with the same polarity it entered with. The storage array, command decoding and analog output timing are outside this block.

Top module: `sdr_mask_path`

## Requirements
- R1: During a write beat, `arr_wr_en[i]` is low in that same cycle when `lane_mask[i]` is high, and high when `lane_mask[i]` is low.
- R2: When `wr_beat` is low, every bit of `arr_wr_en` is low.
- R3: Lane 0 (mask bit 0) covers data bits 7:0 and lane 1 (mask bit 1) covers bits 15:8, for both write enables and output enables.
- R4: `bus_oe[i]`, seen after clock edge k+1, equals `rd_beat & ~lane_mask[i]` as sampled at edge k. This is a lag of exactly two clocks.
- R5: While `rst` is high at a clock edge, the output enables clear to 0, `burst_pos` clears to 0 and `bus_out` reads zero.
- R6: A lane with its output enable high drives `arr_rd_data` for that lane onto `bus_out` without inversion. A lane with its output enable low drives zero.
- R7: Each beat (either `wr_beat` or `rd_beat` high) without `burst_start` moves `burst_pos` forward by one, modulo 2^BURST_W, whatever the mask value.
- R8: A beat with `burst_start` high sets `burst_pos` to 1 after the edge. This marks that beat as position 0 being consumed.
- R9: `arr_wr_data` equals `wr_data` bit for bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_beat | input | 1 | Write data beat valid this cycle |
| rd_beat | input | 1 | Read data beat requested this cycle |
| burst_start | input | 1 | Current beat is the first of a burst |
| lane_mask | input | LANES (2) | Per-byte mask, active high |
| wr_data | input | LANES*LANE_W (16) | Write data from the bus |
| arr_rd_data | input | LANES*LANE_W (16) | Read data from the array, aligned to the output cycle |
| arr_wr_en | output | LANES (2) | Per-byte write enables toward the array |
| arr_wr_data | output | LANES*LANE_W (16) | Write data toward the array |
| bus_oe | output | LANES (2) | Per-byte output enables |
| bus_out | output | LANES*LANE_W (16) | Output bus data, zero on disabled lanes |
| burst_pos | output | BURST_W (3) | Beats consumed in the current burst |

## Verification
The bench builds the block with its defaults: two 8-bit lanes, a read lag of 2 and a 3-bit beat counter. The 3-bit counter lets a run of nine beats wrap the count, and long random streams wrap it many times. With two lanes, all four mask patterns occur on both write and read beats, including overlapping write and read beats. The bench keeps a small array of its own that updates only through the block's write enables. Reading that array back shows whether masked bytes kept their old contents.

// File: rtl/sdr_mask_pkg.sv
package sdr_mask_pkg;

  // A lane is active on a beat only when its mask is low.
  function automatic logic lane_keep(input logic beat, input logic mask);
    return beat & ~mask;
  endfunction

  // Gate one lane of data with its enable; polarity is never changed.
  function automatic logic [7:0] lane_gate8(input logic [7:0] d, input logic en);
    return en ? d : 8'h00;
  endfunction

endpackage

// File: rtl/sdr_wr_mask.sv
module sdr_wr_mask #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                      wr_beat,
  input  logic [LANES-1:0]          lane_mask,
  input  logic [LANES*LANE_W-1:0]   wr_data,
  output logic [LANES-1:0]          arr_wr_en,
  output logic [LANES*LANE_W-1:0]   arr_wr_data
);
  import sdr_mask_pkg::*;

  // Write masking acts in the cycle the mask is sampled: no register here.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign arr_wr_en[g] = lane_keep(wr_beat, lane_mask[g]);
  end

  assign arr_wr_data = wr_data;

endmodule

// File: rtl/sdr_rd_mask.sv
module sdr_rd_mask #(
  parameter int LANES    = 2,
  parameter int LANE_W   = 8,
  parameter int READ_LAG = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      rd_beat,
  input  logic [LANES-1:0]          lane_mask,
  input  logic [LANES*LANE_W-1:0]   arr_rd_data,
  output logic [LANES-1:0]          rd_keep,
  output logic [LANES-1:0]          bus_oe,
  output logic [LANES*LANE_W-1:0]   bus_out
);
  import sdr_mask_pkg::*;

  localparam int LAST = READ_LAG - 1;

  logic [LANES-1:0] stage_q [READ_LAG];

  for (genvar g = 0; g < LANES; g++) begin : g_keep
    assign rd_keep[g] = lane_keep(rd_beat, lane_mask[g]);
  end

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= rd_keep;
  end

  for (genvar s = 1; s < READ_LAG; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign bus_oe = stage_q[LAST];

  for (genvar g = 0; g < LANES; g++) begin : g_out
    assign bus_out[g*LANE_W +: LANE_W] =
      bus_oe[g] ? arr_rd_data[g*LANE_W +: LANE_W] : '0;
  end

endmodule

// File: rtl/sdr_burst_count.sv
module sdr_burst_count #(
  parameter int BURST_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               beat,
  input  logic               burst_start,
  output logic [BURST_W-1:0] burst_pos
);

  function automatic logic [BURST_W-1:0] next_pos(
    input logic [BURST_W-1:0] cur, input logic start);
    return start ? BURST_W'(1) : BURST_W'(cur + 1'b1);
  endfunction

  logic [BURST_W-1:0] pos_q;

  always_ff @(posedge clk) begin
    if (rst)       pos_q <= '0;
    else if (beat) pos_q <= next_pos(pos_q, burst_start);
  end

  assign burst_pos = pos_q;

endmodule

// File: rtl/sdr_mask_path.sv
module sdr_mask_path #(
  parameter int LANES    = 2,
  parameter int LANE_W   = 8,
  parameter int READ_LAG = 2,
  parameter int BURST_W  = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_beat,
  input  logic                      rd_beat,
  input  logic                      burst_start,
  input  logic [LANES-1:0]          lane_mask,
  input  logic [LANES*LANE_W-1:0]   wr_data,
  input  logic [LANES*LANE_W-1:0]   arr_rd_data,
  output logic [LANES-1:0]          arr_wr_en,
  output logic [LANES*LANE_W-1:0]   arr_wr_data,
  output logic [LANES-1:0]          bus_oe,
  output logic [LANES*LANE_W-1:0]   bus_out,
  output logic [BURST_W-1:0]        burst_pos
);

  logic             beat_any;
  logic [LANES-1:0] rd_keep;

  assign beat_any = wr_beat | rd_beat;

  sdr_wr_mask #(.LANES(LANES), .LANE_W(LANE_W)) u_wr (
    .wr_beat     (wr_beat),
    .lane_mask   (lane_mask),
    .wr_data     (wr_data),
    .arr_wr_en   (arr_wr_en),
    .arr_wr_data (arr_wr_data)
  );

  sdr_rd_mask #(.LANES(LANES), .LANE_W(LANE_W), .READ_LAG(READ_LAG)) u_rd (
    .clk         (clk),
    .rst         (rst),
    .rd_beat     (rd_beat),
    .lane_mask   (lane_mask),
    .arr_rd_data (arr_rd_data),
    .rd_keep     (rd_keep),
    .bus_oe      (bus_oe),
    .bus_out     (bus_out)
  );

  sdr_burst_count #(.BURST_W(BURST_W)) u_cnt (
    .clk         (clk),
    .rst         (rst),
    .beat        (beat_any),
    .burst_start (burst_start),
    .burst_pos   (burst_pos)
  );

endmodule

// File: rtl/sdr_mask_path_chk.sv
module sdr_mask_path_chk #(
  parameter int LANES    = 2,
  parameter int LANE_W   = 8,
  parameter int BURST_W  = 3
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      wr_beat,
  input logic                      rd_beat,
  input logic                      burst_start,
  input logic [LANES-1:0]          lane_mask,
  input logic [LANES*LANE_W-1:0]   wr_data,
  input logic [LANES*LANE_W-1:0]   arr_rd_data,
  input logic [LANES-1:0]          arr_wr_en,
  input logic [LANES*LANE_W-1:0]   arr_wr_data,
  input logic [LANES-1:0]          bus_oe,
  input logic [LANES*LANE_W-1:0]   bus_out,
  input logic [BURST_W-1:0]        burst_pos,
  input logic                      beat_any
);

  // Clock edges seen since reset, saturating at 2, so the read-lag check
  // never looks back into the reset period.
  logic [1:0] age_q;
  always_ff @(posedge clk) begin
    if (rst)              age_q <= 2'd0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    a_r1_wr_blocked: assert property (@(posedge clk) disable iff (rst)
      (wr_beat && lane_mask[g]) |-> !arr_wr_en[g]);
    a_r1_wr_open: assert property (@(posedge clk) disable iff (rst)
      (wr_beat && !lane_mask[g]) |-> arr_wr_en[g]);
    // R3 and R4: mask bit g disables lane g exactly two edges later
    a_r4_read_lag: assert property (@(posedge clk) disable iff (rst)
      (age_q == 2'd2) |-> (bus_oe[g] == $past(rd_beat && !lane_mask[g], 2)));
    a_r6_lane_zero: assert property (@(posedge clk) disable iff (rst)
      !bus_oe[g] |-> (bus_out[g*LANE_W +: LANE_W] == '0));
    a_r6_lane_pass: assert property (@(posedge clk) disable iff (rst)
      bus_oe[g] |-> (bus_out[g*LANE_W +: LANE_W] == arr_rd_data[g*LANE_W +: LANE_W]));
  end

  a_r2_idle_no_write: assert property (@(posedge clk) disable iff (rst)
    !wr_beat |-> (arr_wr_en == '0));
  a_r5_reset_clear: assert property (@(posedge clk)
    rst |=> (bus_oe == '0 && burst_pos == '0));
  a_r7_advance: assert property (@(posedge clk) disable iff (rst)
    (beat_any && !burst_start) |=> (burst_pos == BURST_W'($past(burst_pos) + 1'b1)));
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !beat_any |=> $stable(burst_pos));
  a_r8_restart: assert property (@(posedge clk) disable iff (rst)
    (beat_any && burst_start) |=> (burst_pos == BURST_W'(1)));
  a_r9_data_pass: assert property (@(posedge clk) disable iff (rst)
    arr_wr_data == wr_data);

endmodule

bind sdr_mask_path sdr_mask_path_chk #(
  .LANES(LANES), .LANE_W(LANE_W), .BURST_W(BURST_W)
) chk_i (
  .clk(clk), .rst(rst), .wr_beat(wr_beat), .rd_beat(rd_beat),
  .burst_start(burst_start), .lane_mask(lane_mask), .wr_data(wr_data),
  .arr_rd_data(arr_rd_data), .arr_wr_en(arr_wr_en), .arr_wr_data(arr_wr_data),
  .bus_oe(bus_oe), .bus_out(bus_out), .burst_pos(burst_pos), .beat_any(beat_any)
);

// File: tb/sdr_mask_path_test.sv
module sdr_mask_path_test;
  localparam int LANES = 2, LANE_W = 8, BW = 3, DW = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_beat = 0, rd_beat = 0, burst_start = 0;
  logic [LANES-1:0] lane_mask = '0;
  logic [DW-1:0] wr_data = '0, arr_rd_data;
  logic [LANES-1:0] arr_wr_en, bus_oe;
  logic [DW-1:0] arr_wr_data, bus_out;
  logic [BW-1:0] burst_pos;

  always #5 clk = ~clk;

  sdr_mask_path uut (
    .clk(clk), .rst(rst), .wr_beat(wr_beat), .rd_beat(rd_beat),
    .burst_start(burst_start), .lane_mask(lane_mask), .wr_data(wr_data),
    .arr_rd_data(arr_rd_data), .arr_wr_en(arr_wr_en), .arr_wr_data(arr_wr_data),
    .bus_oe(bus_oe), .bus_out(bus_out), .burst_pos(burst_pos)
  );

  int n_cmp = 0, n_bad = 0;
  logic [2:0] wr_addr = 0, rd_addr = 0, ra1 = 0, ra2 = 0;
  logic [DW-1:0] mem [8];     // written only through the block's enables
  logic [DW-1:0] shadow [8];  // written by the bench's own rule
  logic [LANES-1:0] e1 = '0, e2 = '0;
  logic [BW-1:0] exp_pos = '0;

  assign arr_rd_data = mem[ra2];

  function automatic logic [LANES-1:0] want_en(input logic beat, input logic [LANES-1:0] m);
    return beat ? ~m : '0;
  endfunction

  function automatic logic [DW-1:0] lanes_only(input logic [DW-1:0] d, input logic [LANES-1:0] en);
    logic [DW-1:0] r = d;
    if (!en[0]) r[7:0]  = 8'h00;   // lane 0 = bits 7:0
    if (!en[1]) r[15:8] = 8'h00;   // lane 1 = bits 15:8
    return r;
  endfunction

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] nw,
                                          input logic [LANES-1:0] en);
    return lanes_only(nw, en) | lanes_only(old, ~en);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      e1 <= '0; e2 <= '0; exp_pos <= '0;
    end else begin
      e1 <= want_en(rd_beat, lane_mask);
      e2 <= e1;
      if (wr_beat | rd_beat) exp_pos <= burst_start ? BW'(1) : BW'(exp_pos + 1'b1);
      if (wr_beat) shadow[wr_addr] <= merge(shadow[wr_addr], wr_data, ~lane_mask);
    end
    if (arr_wr_en[0]) mem[wr_addr][7:0]  <= arr_wr_data[7:0];
    if (arr_wr_en[1]) mem[wr_addr][15:8] <= arr_wr_data[15:8];
    ra1 <= rd_addr;
    ra2 <= ra1;
  end

  task automatic chk(input string req, input logic ok, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R1/R2/R3 write enables", arr_wr_en === want_en(wr_beat, lane_mask),
        32'(arr_wr_en), 32'(want_en(wr_beat, lane_mask)));
    chk("R9 write data", arr_wr_data === wr_data, 32'(arr_wr_data), 32'(wr_data));
    chk("R4 output enable lag", bus_oe === e2, 32'(bus_oe), 32'(e2));
    chk("R6 output data", bus_out === lanes_only(shadow[ra2], e2),
        32'(bus_out), 32'(lanes_only(shadow[ra2], e2)));
    chk("R7/R8 burst position", burst_pos === exp_pos, 32'(burst_pos), 32'(exp_pos));
  endtask

  task automatic step(input logic w, input logic r, input logic st, input logic [1:0] m,
                      input logic [DW-1:0] d, input logic [2:0] wa, input logic [2:0] ra);
    @(negedge clk);
    wr_beat = w; rd_beat = r; burst_start = st; lane_mask = m;
    wr_data = d; wr_addr = wa; rd_addr = ra;
    #1;
    check_all();
  endtask

  logic done = 1'b0;
  initial begin
    #(200000 * 10);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin mem[i] = '0; shadow[i] = '0; end
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    #1;
    // R5: reset state
    chk("R5 reset oe", bus_oe === '0, 32'(bus_oe), 0);
    chk("R5 reset pos", burst_pos === '0, 32'(burst_pos), 0);
    chk("R5 reset bus", bus_out === '0, 32'(bus_out), 0);
    @(negedge clk); rst = 1'b0;

    // preload four words unmasked
    for (int i = 0; i < 4; i++) step(1, 0, i == 0, 2'b00, 16'hAAAA, 3'(i), 0);
    // R1: four-beat write, mask patterns 00,01,10,11
    step(1, 0, 1, 2'b00, 16'h1111, 0, 0);
    step(1, 0, 0, 2'b01, 16'h2222, 1, 0);
    step(1, 0, 0, 2'b10, 16'h3333, 2, 0);
    step(1, 0, 0, 2'b11, 16'h4444, 3, 0);
    // R4/R6: four-beat read with mixed masks, then flush
    step(0, 1, 1, 2'b00, 0, 0, 0);
    step(0, 1, 0, 2'b10, 0, 0, 1);
    step(0, 1, 0, 2'b01, 0, 0, 2);
    step(0, 1, 0, 2'b11, 0, 0, 3);
    step(0, 0, 0, 2'b00, 0, 0, 0);
    step(0, 0, 0, 2'b00, 0, 0, 0);
    // R1: masked bytes kept old contents (read all unmasked)
    for (int i = 0; i < 4; i++) step(0, 1, 0, 2'b00, 0, 0, 3'(i));
    step(0, 0, 0, 2'b00, 0, 0, 0);
    step(0, 0, 0, 2'b00, 0, 0, 0);
    chk("R1 kept word1", shadow[1] === 16'h22AA, 32'(shadow[1]), 32'h22AA);
    chk("R1 kept word3", mem[3] === 16'hAAAA, 32'(mem[3]), 32'hAAAA);
    chk("R1 array word2", mem[2] === 16'hAA33, 32'(mem[2]), 32'hAA33);
    // R7: nine fully masked beats wrap the 3-bit count to 1
    step(0, 1, 1, 2'b11, 0, 0, 0);
    for (int i = 0; i < 8; i++) step(1, 0, 0, 2'b11, 16'hFFFF, 5, 0);
    step(0, 0, 0, 2'b00, 0, 0, 0);
    chk("R7 wrap", burst_pos === 3'd1, 32'(burst_pos), 1);

    // random traffic
    for (int i = 0; i < 2000; i++)
      step(1'($urandom), 1'($urandom), ($urandom % 5) == 0, 2'($urandom),
           16'($urandom), 3'($urandom), 3'($urandom));

    // R5: reset mid-stream clears enables and count
    @(negedge clk); rst = 1'b1; rd_beat = 1'b1; lane_mask = '0;
    @(negedge clk); #1;
    chk("R5 mid reset oe", bus_oe === '0, 32'(bus_oe), 0);
    chk("R5 mid reset pos", burst_pos === '0, 32'(burst_pos), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule